// File: doc/BRIEF.md
# SRAM March-Test Self-Test Sequencer

This block is a built-in self-test engine for one single-port synchronous SRAM. It has a word width of `DW` bits and a depth of `DEPTH` words. When a test is requested, the engine takes over the memory-side address, write-enable and write-data lines. It then makes five passes over the array. The first pass fills the memory with all-zero words. Four march elements follow, and each one performs a read, a write of the inverse word and a read-back at every address before it moves to the next address. The first two elements walk the addresses upward and the last two walk them downward. This ordering lets aliasing between addresses and shorts between neighbouring cells show up as miscompares. A plain fill-then-check pass would miss them.

Every read is compared against the expected word across the full width. The first miscompare raises `fail` and freezes the failing address, the element number and the operation number. The run then continues to the end, so the end-of-test pulse `done` always arrives after the same number of cycles.

States: `ST_IDLE` waits for `start`. `ST_FILL` writes zero at one address per cycle. `ST_RD_ISSUE` presents the first read of an address. `ST_CMP_WR` compares that read and writes the inverse word. `ST_RB_ISSUE` presents the read-back. `ST_RB_CMP` compares the read-back and then advances the address, advances the element or finishes. `ST_DONE` pulses `done` for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_FILL` on `start`.
- `ST_FILL` goes to itself until the last address, then to `ST_RD_ISSUE`.
- `ST_RD_ISSUE` goes to `ST_CMP_WR`.
- `ST_CMP_WR` goes to `ST_RB_ISSUE`.
- `ST_RB_ISSUE` goes to `ST_RB_CMP`.
- `ST_RB_CMP` goes to `ST_RD_ISSUE` while addresses or elements remain, and to `ST_DONE` after element 4 ends at address 0.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `mbist_march_ctrl`

## Requirements
- R1: A `start` seen high in the idle state begins a fill pass that writes the all-zero word once to each address, in order 0, 1, …, DEPTH-1.
- R2: After the fill, four march elements run. At each address, elements 1 and 3 do read-expect-zeros, write all-ones, read-expect-ones. Elements 2 and 4 do read-expect-ones, write all-zeros, read-expect-zeros. The only words ever written are all-zeros and all-ones.
- R3: Elements 1 and 2 visit addresses 0 up to DEPTH-1. Elements 3 and 4 visit DEPTH-1 down to 0.
- R4: Each read is compared one cycle after it is issued, because the memory has a one-cycle read latency. The fill takes one cycle per address and each element takes four cycles per address. `done` is therefore high in the cycle that follows 17·DEPTH busy cycles after the clock edge that accepts `start`.
- R5: `done` is high for exactly one cycle per run, and the engine is idle afterwards.
- R6: A difference in any bit of a compared word sets `fail`. `fail` stays high until the next accepted `start` clears it.
- R7: On the first miscompare of a run, `fail_addr` takes the address and `fail_element` takes the element (1 to 4). `fail_op` takes the operation: 0 for the first read, 2 for the read-back. Later miscompares leave all three unchanged.
- R8: `start` is ignored while a run is in progress. A pulse mid-run neither restarts the run nor changes its length or its write sequence.
- R9: A run that has failed still completes all five passes and reaches `done` after the same number of cycles.
- R10: After reset, `done`, `fail` and `mem_we` are low and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Requests a run; accepted only when idle |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | Sticky miscompare flag for the latest run |
| fail_addr | output | AW | Address of the first miscompare |
| fail_element | output | 3 | March element (1–4) of the first miscompare |
| fail_op | output | 2 | Operation of the first miscompare: 0 first read, 2 read-back |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after the read |

## Verification
The assertions assume a memory that returns the data for the address presented on the previous cycle and a `start` that is synchronous to `clk`. The bench builds that memory as a registered model, and every stimulus change it makes falls on a falling clock edge. Faults are injected only in the bench model: stuck bits and address aliasing that corrupts a second word. The design itself therefore always sees well-formed timing, and only the data it reads back departs from the ideal.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_RD_ISSUE,
        ST_CMP_WR,
        ST_RB_ISSUE,
        ST_RB_CMP,
        ST_DONE
    } mbist_state_t;

    localparam logic [1:0] OP_FIRST_RD = 2'd0;
    localparam logic [1:0] OP_WRITE    = 2'd1;
    localparam logic [1:0] OP_READBACK = 2'd2;

    localparam logic [2:0] ELEM_FILL = 3'd0;
    localparam logic [2:0] ELEM_LAST = 3'd4;

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_lo,
    input  logic          load_hi,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] addr,
    output logic          at_end
);

    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_lo) begin
            addr <= '0;
        end else if (load_hi) begin
            addr <= TOP_ADDR;
        end else if (step) begin
            addr <= down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_end = down ? (addr == '0) : (addr == TOP_ADDR);

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_lo && !load_hi && !down) |=> (addr == $past(addr) + 1'b1)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_lo && !load_hi && down) |=> (addr == $past(addr) - 1'b1)); // R3

endmodule

// File: rtl/mbist_fail_cap.sv
module mbist_fail_cap #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          check,
    input  logic [DW-1:0] rdata,
    input  logic [DW-1:0] expect_word,
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    cur_elem,
    input  logic [1:0]    cur_op,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [2:0]    fail_elem,
    output logic [1:0]    fail_op
);

    logic mismatch;

    assign mismatch = check && (rdata != expect_word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
        end else if (clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= cur_addr;
            fail_elem <= cur_elem;
            fail_op   <= cur_op;
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail); // R6

    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_op))); // R7

endmodule

// File: rtl/mbist_march_fsm.sv
module mbist_march_fsm
    import mbist_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          at_end,
    output logic          load_lo,
    output logic          load_hi,
    output logic          step,
    output logic          down,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          check,
    output logic [DW-1:0] expect_word,
    output logic [1:0]    op,
    output logic [2:0]    elem,
    output logic          clear,
    output logic          done
);

    localparam logic [DW-1:0] ZEROS = '0;
    localparam logic [DW-1:0] ONES  = '1;

    mbist_state_t state, state_n;
    logic [2:0]   elem_n;
    logic [DW-1:0] first_word;

    // Elements 1 and 3 start from zeros, 2 and 4 from ones.
    assign first_word = elem[0] ? ZEROS : ONES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            elem  <= ELEM_FILL;
        end else begin
            state <= state_n;
            elem  <= elem_n;
        end
    end

    always_comb begin
        state_n = state;
        elem_n  = elem;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_FILL;
                    elem_n  = ELEM_FILL;
                end
            end
            ST_FILL: begin
                if (at_end) begin
                    state_n = ST_RD_ISSUE;
                    elem_n  = 3'd1;
                end
            end
            ST_RD_ISSUE: state_n = ST_CMP_WR;
            ST_CMP_WR:   state_n = ST_RB_ISSUE;
            ST_RB_ISSUE: state_n = ST_RB_CMP;
            ST_RB_CMP: begin
                if (at_end && elem == ELEM_LAST) begin
                    state_n = ST_DONE;
                end else begin
                    state_n = ST_RD_ISSUE;
                    if (at_end) elem_n = elem + 3'd1;
                end
            end
            ST_DONE: state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        load_lo     = 1'b0;
        load_hi     = 1'b0;
        step        = 1'b0;
        mem_we      = 1'b0;
        mem_wdata   = ZEROS;
        check       = 1'b0;
        expect_word = ZEROS;
        op          = OP_FIRST_RD;
        clear       = 1'b0;
        done        = 1'b0;
        down        = (elem >= 3'd3);
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load_lo = 1'b1;
                    clear   = 1'b1;
                end
            end
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_wdata = ZEROS;
                if (at_end) load_lo = 1'b1;
                else        step    = 1'b1;
            end
            ST_RD_ISSUE: begin
                op = OP_FIRST_RD;
            end
            ST_CMP_WR: begin
                check       = 1'b1;
                expect_word = first_word;
                op          = OP_FIRST_RD;
                mem_we      = 1'b1;
                mem_wdata   = ~first_word;
            end
            ST_RB_ISSUE: begin
                op = OP_READBACK;
            end
            ST_RB_CMP: begin
                check       = 1'b1;
                expect_word = ~first_word;
                op          = OP_READBACK;
                if (!at_end) begin
                    step = 1'b1;
                end else if (elem == 3'd1) begin
                    load_lo = 1'b1;
                end else if (elem != ELEM_LAST) begin
                    load_hi = 1'b1;
                end
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_ELEM_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (elem >= $past(elem))); // R8

    AST_WRITE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == ZEROS || mem_wdata == ONES)); // R2

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [2:0]    fail_element,
    output logic [1:0]    fail_op,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);

    logic          load_lo, load_hi, step, down, at_end;
    logic          check, clear;
    logic [DW-1:0] expect_word;
    logic [1:0]    op;
    logic [2:0]    elem;

    mbist_march_fsm #(.DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .at_end      (at_end),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .step        (step),
        .down        (down),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata),
        .check       (check),
        .expect_word (expect_word),
        .op          (op),
        .elem        (elem),
        .clear       (clear),
        .done        (done)
    );

    mbist_addr_gen #(.DEPTH(DEPTH), .AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (load_lo),
        .load_hi (load_hi),
        .step    (step),
        .down    (down),
        .addr    (mem_addr),
        .at_end  (at_end)
    );

    mbist_fail_cap #(.AW(AW), .DW(DW)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .check       (check),
        .rdata       (mem_rdata),
        .expect_word (expect_word),
        .cur_addr    (mem_addr),
        .cur_elem    (elem),
        .cur_op      (op),
        .fail        (fail),
        .fail_addr   (fail_addr),
        .fail_elem   (fail_element),
        .fail_op     (fail_op)
    );

endmodule

// File: tb/tb_mbist_march_ctrl.sv
module tb_mbist_march_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int DW = 8;
    localparam int AW = $clog2(N);
    localparam int RUN_CYCLES = 17 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, fail, mem_we;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [2:0]    fail_element;
    logic [1:0]    fail_op;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    // Fault model: 0 none, 1 stuck bit, 2 write aliasing
    int            fmode = 0;
    int            sa_addr = 0, sa_bit = 0;
    logic          sa_val = 1'b0;
    int            agg = 0, vic = 0;
    logic [DW-1:0] mem [N];
    logic [DW-1:0] rd_tmp;

    bit mon_en = 1'b0;
    int wr_idx = 0;
    int mon_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbist_march_ctrl #(.DEPTH(N), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_element(fail_element), .fail_op(fail_op),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (fmode == 2 && int'(mem_addr) == agg) mem[vic] <= mem_wdata;
        end
        rd_tmp = mem[mem_addr];
        if (fmode == 1 && int'(mem_addr) == sa_addr) rd_tmp[sa_bit] = sa_val;
        mem_rdata <= rd_tmp;
    end

    // Write-order monitor for R1, R2, R3
    always @(negedge clk) begin
        if (mon_en && mem_we) begin
            int ea;
            logic [DW-1:0] ed;
            if (wr_idx < N) begin
                ea = wr_idx;
                ed = '0;
            end else begin
                int e, k;
                e  = (wr_idx - N) / N + 1;
                k  = (wr_idx - N) % N;
                ea = (e <= 2) ? k : N - 1 - k;
                ed = (e % 2 == 1) ? '1 : '0;
            end
            if (int'(mem_addr) != ea || mem_wdata != ed) mon_err++;
            wr_idx++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_march(input bit poke_start, output int cycles);
        wr_idx = 0;
        mon_err = 0;
        mon_en = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cycles = 0;
        while (!done && cycles < 20 * RUN_CYCLES) begin
            cycles++;
            if (poke_start && cycles == 40) start = 1'b1;
            if (poke_start && cycles == 41) start = 1'b0;
            @(negedge clk);
        end
        mon_en = 1'b0;
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual %0d expected %0d", cycles, RUN_CYCLES);
        end
    endtask

    task automatic check_fail(input string req, input int ea, input int ee, input int eo);
        int cyc;
        run_march(1'b0, cyc);
        chk(cyc == RUN_CYCLES, "R9", "cycles with fault", cyc, RUN_CYCLES);
        chk(fail == 1'b1, "R6", "fail set", fail, 1);
        chk(int'(fail_addr) == ea, req, "fail_addr", fail_addr, ea);
        chk(int'(fail_element) == ee, req, "fail_element", fail_element, ee);
        chk(int'(fail_op) == eo, req, "fail_op", fail_op, eo);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done single cycle", done, 0);
        repeat (5) @(negedge clk);
        chk(fail == 1'b1, "R6", "fail sticky", fail, 1);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R10", "done after reset", done, 0);
        chk(fail == 1'b0, "R10", "fail after reset", fail, 0);
        chk(mem_we == 1'b0, "R10", "mem_we after reset", mem_we, 0);
    endtask

    task automatic t_clean(input bit poke, input string req);
        int cyc;
        fmode = 0;
        run_march(poke, cyc);
        chk(cyc == RUN_CYCLES, req, "run length", cyc, RUN_CYCLES);
        chk(wr_idx == 5 * N, "R2", "write count", wr_idx, 5 * N);
        chk(mon_err == 0, "R3", "write address/data order", mon_err, 0);
        chk(fail == 1'b0, "R6", "clean run fail low", fail, 0);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done single cycle", done, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mem[i] = '1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean(1'b0, "R4");            // R1 R2 R3 R4 R5
        t_clean(1'b1, "R8");            // start pulse mid-run ignored
        fmode = 1; sa_addr = 5; sa_bit = 3; sa_val = 1'b0;
        check_fail("R7", 5, 1, 2);      // stuck-at-0 caught on read-back
        fmode = 1; sa_addr = 0; sa_bit = DW - 1; sa_val = 1'b1;
        check_fail("R7", 0, 1, 0);      // stuck-at-1 on MSB, first read
        fmode = 2; agg = 3; vic = 10;
        check_fail("R3", 10, 1, 0);     // alias upward, ascending element
        fmode = 2; agg = 10; vic = 3;
        check_fail("R3", 3, 3, 0);      // alias downward, descending element
        t_clean(1'b0, "R6");            // fail cleared by next start
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule